// File: doc/BRIEF.md
# Processor-Side Channel Coprocessor

This block sits on a processor's simple single-cycle memory bus and connects it to two channel adapters over one shared internal bus. An address decoder turns each processor access into a one-hot window select. A write to the output window hands one 16-bit word to a request/acknowledge output channel. A read of the input window takes the oldest word from a small receive FIFO that is filled from a valid/ready input channel. Two register windows hold the interrupt status and the interrupt mask.

Each adapter reports an event. The input adapter reports when it captures a word, and the output adapter reports when its handshake completes. These events set pending bits. The processor interrupt is a registered OR of the pending bits that are enabled in the mask. Software clears a pending bit by writing a one to it.

Top module: `comm_coproc`

## Requirements
- R1: After reset, `cpu_irq` and `hs_req` are low, `in_ready` and `cpu_ready` are high, the FIFO is empty, and the status and mask registers read 0.
- R2: The byte addresses 0x0 (output word), 0x4 (input FIFO), 0x8 (status) and 0xC (mask) each select exactly one window. Any other address on the 5-bit bus reads as 0. A write to such an address changes no state, and a read of it pops nothing.
- R3: A write to 0x0 while `hs_req` is low puts `cpu_wdata[15:0]` on `hs_data` and raises `hs_req` at that clock edge. `hs_req` and `hs_data` then hold until `hs_ack` is seen high at an edge, and `hs_req` falls at that edge. A read of 0x0 returns the held word, zero-extended.
- R4: A write to 0x0 while `hs_req` is high drives `cpu_ready` low in that cycle and is not taken. The processor holds the access, and it is taken in the first cycle with `hs_req` low. `cpu_ready` is low in no other case.
- R5: `in_ready` is high while the FIFO holds fewer than 4 words. A word on `in_data` is captured at an edge where `in_valid` and `in_ready` are both high. A word offered while the FIFO is full is dropped.
- R6: A read of 0x4 returns the oldest stored word, zero-extended, and removes it. Words come out in arrival order. A read of an empty FIFO returns 0 and changes nothing.
- R7: Status bit 0 sets at the edge where the FIFO captures a word. Status bit 1 sets at the edge where `hs_req` falls.
- R8: Writing to 0x8 clears every status bit written as 1 and keeps every bit written as 0. If a bit is set and cleared in the same cycle, it ends set.
- R9: Mask bits [1:0] at 0xC can be read and written. Upper write bits are ignored, and the upper read bits are 0.
- R10: `cpu_irq` equals the OR of (status AND mask) as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Processor access valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 5 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the access cycle |
| cpu_ready | output | 1 | Low while an access must be held |
| cpu_irq | output | 1 | Interrupt request to the processor |
| hs_req | output | 1 | Output channel request |
| hs_data | output | 16 | Output channel word |
| hs_ack | input | 1 | Output channel acknowledge |
| in_valid | input | 1 | Input channel word valid |
| in_data | input | 16 | Input channel word |
| in_ready | output | 1 | Input channel can accept a word |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a software clear of a status bit and the arrival that sets that bit. The bench offers an input word in the same cycle as a write-one-to-clear to 0x8, then reads the status back and expects the bit still set. The second pair is a write to the output window and the acknowledge that ends the transfer before it. The bench keeps the stalled write on the bus and raises `hs_ack`. It expects `cpu_ready` to go high only once `hs_req` has fallen, and the new word to appear on the next edge with a fresh request.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
    // register windows on the internal bus, indexed by address bits [3:2]
    localparam int NUM_WIN  = 4;
    localparam int WIN_HS   = 0;
    localparam int WIN_FIFO = 1;
    localparam int WIN_STAT = 2;
    localparam int WIN_MASK = 3;
    // interrupt sources
    localparam int NUM_IRQ    = 2;
    localparam int IRQ_ARRIVE = 0;
    localparam int IRQ_SENT   = 1;
endpackage

// File: rtl/cc_addr_decode.sv
`timescale 1ns/1ps
module cc_addr_decode #(
    parameter int ADDR_W  = 5,
    parameter int NUM_WIN = cc_pkg::NUM_WIN
) (
    input  logic               bus_en,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] win_sel
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int LSB   = 2;
    localparam int TOP   = LSB + IDX_W;

    logic upper_clear;

    generate
        if (ADDR_W > TOP) begin : g_upper
            assign upper_clear = (addr[ADDR_W-1:TOP] == '0);
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        win_sel = '0;
        if (bus_en && (addr[LSB-1:0] == '0) && upper_clear) begin
            win_sel[addr[TOP-1:LSB]] = 1'b1;
        end
    end
endmodule

// File: rtl/cc_hs_out.sv
`timescale 1ns/1ps
module cc_hs_out #(
    parameter int DATA_W = 32,
    parameter int CHAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [CHAN_W-1:0] wdata,
    input  logic              hs_ack,
    output logic              hs_req,
    output logic [CHAN_W-1:0] hs_data,
    output logic [DATA_W-1:0] rdata,
    output logic              stall,
    output logic              done
);
    typedef struct packed {
        logic              req;
        logic [CHAN_W-1:0] data;
    } hs_state_t;

    hs_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        stall = 1'b0;
        if (st_q.req && hs_ack) begin
            st_d.req = 1'b0;
        end
        if (sel && wr) begin
            if (st_q.req) begin
                stall = 1'b1;
            end else begin
                st_d.req  = 1'b1;
                st_d.data = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_req  = st_q.req;
    assign hs_data = st_q.data;
    assign rdata   = DATA_W'(st_q.data);
    assign done    = st_q.req && hs_ack;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req && !hs_ack) |=> hs_req);
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_req && !hs_ack) |=> $stable(hs_data));
    // R4
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(hs_data));
endmodule

// File: rtl/cc_fifo_in.sv
`timescale 1ns/1ps
module cc_fifo_in #(
    parameter int DATA_W = 32,
    parameter int CHAN_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_data,
    output logic              in_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              arrive
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CHAN_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic empty, full, push, pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        empty = (st_q.cnt == '0);
        full  = (st_q.cnt == CNT_W'(DEPTH));
        push  = in_valid && !full;
        pop   = sel && rd && !empty;
        st_d  = st_q;
        if (push) begin
            st_d.mem[st_q.wr_ptr] = in_data;
            st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
        end
        if (pop) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = !full;
    assign arrive   = push;
    assign rdata    = (sel && !empty) ? DATA_W'(st_q.mem[st_q.rd_ptr]) : '0;

    // R5
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !(sel && rd)) |=> $stable(st_q.wr_ptr));
    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && empty && !in_valid) |=> (st_q.cnt == '0 && $stable(st_q.rd_ptr)));
endmodule

// File: rtl/cc_irq_ctrl.sv
`timescale 1ns/1ps
module cc_irq_ctrl #(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = cc_pkg::NUM_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic               stat_sel,
    input  logic               mask_sel,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [DATA_W-1:0]  stat_rdata,
    output logic [DATA_W-1:0]  mask_rdata,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        st_d      = st_q;
        clr       = (stat_sel && bus_wr) ? bus_wdata : '0;
        st_d.pend = (st_q.pend & ~clr) | src_set;
        if (mask_sel && bus_wr) begin
            st_d.mask = bus_wdata;
        end
        st_d.irq  = |(st_q.pend & st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_rdata = DATA_W'(st_q.pend);
    assign mask_rdata = DATA_W'(st_q.mask);
    assign irq        = st_q.irq;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            // R8
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                src_set[i] |=> st_q.pend[i]);
            // R8
            w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_sel && bus_wr && bus_wdata[i] && !src_set[i]) |=> !st_q.pend[i]);
        end
    endgenerate

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.pend & st_q.mask)) |=> irq);
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q.pend & st_q.mask)) |=> !irq);
endmodule

// File: rtl/comm_coproc.sv
`timescale 1ns/1ps
module comm_coproc #(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int CHAN_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_irq,
    output logic              hs_req,
    output logic [CHAN_W-1:0] hs_data,
    input  logic              hs_ack,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_data,
    output logic              in_ready
);
    import cc_pkg::*;

    logic [NUM_WIN-1:0] win_sel;
    logic [DATA_W-1:0]  win_rdata [NUM_WIN];
    logic               bus_wr, bus_rd;
    logic               hs_stall, hs_done, fifo_arrive;
    logic [NUM_IRQ-1:0] src_set;
    logic               unused_wdata;

    assign bus_wr       = cpu_sel && cpu_wr;
    assign bus_rd       = cpu_sel && !cpu_wr;
    assign unused_wdata = ^cpu_wdata[DATA_W-1:CHAN_W];

    cc_addr_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_dec (
        .bus_en  (cpu_sel),
        .addr    (cpu_addr),
        .win_sel (win_sel)
    );

    cc_hs_out #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (win_sel[WIN_HS]),
        .wr      (bus_wr),
        .wdata   (cpu_wdata[CHAN_W-1:0]),
        .hs_ack  (hs_ack),
        .hs_req  (hs_req),
        .hs_data (hs_data),
        .rdata   (win_rdata[WIN_HS]),
        .stall   (hs_stall),
        .done    (hs_done)
    );

    cc_fifo_in #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (win_sel[WIN_FIFO]),
        .rd       (bus_rd),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .rdata    (win_rdata[WIN_FIFO]),
        .arrive   (fifo_arrive)
    );

    always_comb begin
        src_set             = '0;
        src_set[IRQ_ARRIVE] = fifo_arrive;
        src_set[IRQ_SENT]   = hs_done;
    end

    cc_irq_ctrl #(.DATA_W(DATA_W), .NUM_SRC(NUM_IRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_set    (src_set),
        .stat_sel   (win_sel[WIN_STAT]),
        .mask_sel   (win_sel[WIN_MASK]),
        .bus_wr     (bus_wr),
        .bus_wdata  (cpu_wdata[NUM_IRQ-1:0]),
        .stat_rdata (win_rdata[WIN_STAT]),
        .mask_rdata (win_rdata[WIN_MASK]),
        .irq        (cpu_irq)
    );

    always_comb begin
        cpu_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_sel[w] && bus_rd) cpu_rdata = cpu_rdata | win_rdata[w];
        end
    end

    assign cpu_ready = !hs_stall;

    // R4
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_sel && cpu_wr && hs_req));
    // R2
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && (win_sel == '0)) |-> (cpu_rdata == '0));
endmodule

// File: tb/comm_coproc_tb_top.sv
`timescale 1ns/1ps
module comm_coproc_tb_top;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int CHAN_W = 16;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_sel = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cpu_ready, cpu_irq, hs_req, in_ready;
    logic [CHAN_W-1:0] hs_data;
    logic              hs_ack = 1'b0;
    logic              in_valid = 1'b0;
    logic [CHAN_W-1:0] in_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    comm_coproc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_irq(cpu_irq),
        .hs_req(hs_req), .hs_data(hs_data), .hs_ack(hs_ack), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1;
        d = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_sel = 1'b0;
    endtask

    task automatic push_word(input logic [CHAN_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_hs();
        @(negedge clk);
        hs_ack = 1'b1;
        @(posedge clk);
        #1;
        hs_ack = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq", DATA_W'(cpu_irq), 0);
        check("R1 hs_req", DATA_W'(hs_req), 0);
        check("R1 in_ready", DATA_W'(in_ready), 1);
        check("R1 cpu_ready", DATA_W'(cpu_ready), 1);
        rst_n = 1'b1;
        bus_read(5'h08, rd); check("R1 status", rd, 0);
        bus_read(5'h0C, rd); check("R1 mask", rd, 0);
        bus_read(5'h04, rd); check("R1 fifo empty", rd, 0);

        // R3 handshake output
        bus_write(5'h00, 32'hABCD_1234);
        check("R3 req up", DATA_W'(hs_req), 1);
        check("R3 data", DATA_W'(hs_data), 32'h1234);
        repeat (2) @(posedge clk);
        #1;
        check("R3 req held", DATA_W'(hs_req), 1);
        check("R3 data held", DATA_W'(hs_data), 32'h1234);
        bus_read(5'h00, rd); check("R3 readback", rd, 32'h1234);

        // R4 write while busy, acknowledge arrives while the write is held
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = 5'h00; cpu_wdata = 32'h0000_5555;
        #1;
        check("R4 ready low", DATA_W'(cpu_ready), 0);
        @(posedge clk);
        #1;
        check("R4 data kept", DATA_W'(hs_data), 32'h1234);
        @(negedge clk);
        hs_ack = 1'b1;
        #1;
        check("R4 ready low with ack", DATA_W'(cpu_ready), 0);
        @(posedge clk);
        #1;
        check("R3 req falls on ack", DATA_W'(hs_req), 0);
        check("R4 ready back", DATA_W'(cpu_ready), 1);
        hs_ack = 1'b0;
        @(posedge clk);
        #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0;
        check("R4 held write taken", DATA_W'(hs_req), 1);
        check("R4 new data", DATA_W'(hs_data), 32'h5555);
        bus_read(5'h08, rd); check("R7 sent bit", rd, 2);
        finish_hs();
        check("R3 second transfer ends", DATA_W'(hs_req), 0);
        bus_write(5'h08, 32'h3);
        bus_read(5'h08, rd); check("R8 cleared", rd, 0);

        // R5 R6 fill, overflow, ordered drain, empty read
        for (int k = 0; k < DEPTH; k++) push_word(CHAN_W'(16'h1000 + k * 16'h0111));
        check("R5 full", DATA_W'(in_ready), 0);
        push_word(16'hDEAD);
        for (int k = 0; k < DEPTH; k++) begin
            bus_read(5'h04, rd);
            check("R6 order", rd, DATA_W'(16'h1000 + k * 16'h0111));
            check("R5 ready after pop", DATA_W'(in_ready), 1);
        end
        bus_read(5'h04, rd); check("R6 empty read", rd, 0);
        bus_read(5'h04, rd); check("R6 empty read again", rd, 0);
        push_word(16'h0042);
        bus_read(5'h04, rd); check("R6 pointers intact", rd, 32'h42);
        bus_read(5'h08, rd); check("R7 arrive bit", rd, 1);
        bus_write(5'h08, 32'h1);

        // R6 push and pop in one cycle
        push_word(16'h0A0A);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h0B0B;
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = 5'h04;
        #1;
        check("R6 pop during push", cpu_rdata, 32'h0A0A);
        @(posedge clk);
        #1;
        in_valid = 1'b0; cpu_sel = 1'b0;
        bus_read(5'h04, rd); check("R6 pushed word kept", rd, 32'h0B0B);
        bus_write(5'h08, 32'h3);

        // R10 interrupt latency
        bus_write(5'h0C, 32'h1);
        push_word(16'h0007);
        check("R10 irq not yet", DATA_W'(cpu_irq), 0);
        @(posedge clk);
        #1;
        check("R10 irq one cycle later", DATA_W'(cpu_irq), 1);
        bus_write(5'h08, 32'h1);
        check("R10 irq still registered", DATA_W'(cpu_irq), 1);
        @(posedge clk);
        #1;
        check("R10 irq drops", DATA_W'(cpu_irq), 0);
        bus_read(5'h04, rd);

        // R8 set wins over clear in the same cycle
        push_word(16'h0011);
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h0022;
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = 5'h08; cpu_wdata = 32'h1;
        @(posedge clk);
        #1;
        in_valid = 1'b0; cpu_sel = 1'b0; cpu_wr = 1'b0;
        bus_read(5'h08, rd); check("R8 set wins", rd, 1);
        bus_write(5'h00, 32'h0);
        finish_hs();
        bus_write(5'h08, 32'h2);
        bus_read(5'h08, rd); check("R8 zero bits kept", rd, 1);
        bus_write(5'h08, 32'h1);
        bus_read(5'h08, rd); check("R8 clear", rd, 0);
        bus_read(5'h04, rd);
        bus_read(5'h04, rd);

        // R9 R10 R7 sweep of mask and pending patterns
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 4; p++) begin
                bus_write(5'h0C, {28'hFFF_FFFF, 4'(m)});
                bus_read(5'h0C, rd); check("R9 mask rw", rd, DATA_W'(m));
                bus_write(5'h08, 32'h3);
                if (p[0]) push_word(16'h0055);
                if (p[1]) begin
                    bus_write(5'h00, 32'h0066);
                    finish_hs();
                end
                repeat (2) @(posedge clk);
                #1;
                check("R10 irq sweep", DATA_W'(cpu_irq), DATA_W'(|(p & m)));
                bus_read(5'h08, rd); check("R7 status sweep", rd, DATA_W'(p));
                if (p[0]) bus_read(5'h04, rd);
            end
        end

        // R2 unmapped addresses
        bus_write(5'h08, 32'h3);
        bus_write(5'h0C, 32'h2);
        push_word(16'h0077);
        for (int a = 0; a < 32; a++) begin
            if (!((a % 4 == 0) && (a <= 12))) begin
                bus_read(ADDR_W'(a), rd); check("R2 unmapped read", rd, 0);
                bus_write(ADDR_W'(a), 32'hFFFF_FFFF);
            end
        end
        check("R2 no handshake", DATA_W'(hs_req), 0);
        bus_read(5'h0C, rd); check("R2 mask unchanged", rd, 2);
        bus_read(5'h08, rd); check("R2 status unchanged", rd, 1);
        bus_read(5'h04, rd); check("R2 fifo not popped", rd, 32'h77);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule